// File: doc/BRIEF.md
# Receive Buffer Host-Read Release Gate

This block decides, for every packet read request from the host side, whether the receive buffer answers with data or refuses the request. A buffer holding a full packet's worth of bytes is always released as a full-size packet. A shorter backlog is held back, which keeps transfers large and host overhead low. It is released only once the serial line has been quiet for more than a set number of character times, or at once when the low-latency switch is on. The buffer fill level, a per-character receive strobe and a character-time tick come from the surrounding UART. The block answers with an accept or refuse pulse and the byte count to move.

The same fill level also drives an automatic request-to-send output for the remote transmitter. The output is withdrawn once the fill reaches a programmable trigger level and given again when host reads drain the buffer below it.

Top module: `rxrel_bulkin_gate`

## Requirements
- R1: While reset is held, and in the first cycle after it, `rsp_ack` and `rsp_nak` are 0, `xfer_len` is 0 and `rts_n` is 1.
- R2: A request sampled with `rd_req`=1 at a clock edge gets exactly one of `rsp_ack` or `rsp_nak`, each high for one cycle after that edge. Without a request, both stay 0.
- R3: If `fifo_level` is 64 or more when a request is sampled, the answer is accept with `xfer_len`=64.
- R4: If `fifo_level` is 0 when a request is sampled, the answer is refuse, in every mode.
- R5: If `fifo_level` is 1 to 63, low latency is off and the line is not idle, the answer is refuse.
- R6: The line is idle once more than 3 `char_tick` pulses (that is, 4) have been registered since the last `rx_char_stb` or since reset. The count saturates there. A request with 1 to 63 bytes on an idle line is accepted with `xfer_len` equal to `fifo_level`.
- R7: With `low_lat_en`=1, a request with 1 to 63 bytes is accepted at once with `xfer_len` equal to `fifo_level`, whatever the idle state.
- R8: An `rx_char_stb` clears the idle count. A strobe in the same cycle as a tick also leaves the count at 0.
- R9: With `rts_auto_en`=1 and a nonzero fill, `rts_n` is 1 from the cycle after `fifo_level` reaches `rts_thresh` or more. It is 0 from the cycle after the fill is below `rts_thresh`.
- R10: With `rts_auto_en`=1 and `fifo_level`=0, `rts_n` is 0 in the next cycle, even when `rts_thresh` is 0.
- R11: With `rts_auto_en`=0, `rts_n` is 1 in the next cycle, whatever the fill.
- R12: `xfer_len` is 0 in every cycle in which `rsp_ack` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_level | input | LVL_W (9) | Bytes currently held in the receive buffer |
| rx_char_stb | input | 1 | One-cycle pulse per character written to the buffer |
| char_tick | input | 1 | One-cycle pulse per elapsed character time |
| low_lat_en | input | 1 | Release short backlogs without waiting for idle |
| rts_auto_en | input | 1 | Enable automatic request-to-send control |
| rts_thresh | input | LVL_W (9) | Fill level at which request-to-send is withdrawn |
| rd_req | input | 1 | Host read request, sampled on the clock edge |
| rsp_ack | output | 1 | Request accepted, data follows |
| rsp_nak | output | 1 | Request refused |
| xfer_len | output | LEN_W (7) | Bytes to move with an accept |
| rts_n | output | 1 | Request-to-send, active low |

## Verification
The hardest state to reach from the ports is the exact boundary of the idle window. The bench restarts the count with a receive strobe and then adds one tick at a time, polling with a request after each. The third tick must still give a refuse and the fourth an accept. A second pass lands a strobe on the same cycle as a tick, to show that the restart wins over the increment. The automatic request-to-send is driven to the threshold from both sides and to an empty buffer with a zero threshold. These are the places where the comparison and the empty override meet.

// File: rtl/rxrel_pkg.sv
package rxrel_pkg;

    typedef enum logic [1:0] {
        DEC_NONE  = 2'd0,
        DEC_NAK   = 2'd1,
        DEC_FULL  = 2'd2,
        DEC_SHORT = 2'd3
    } rel_dec_e;

endpackage

// File: rtl/rxrel_idle_timer.sv
module rxrel_idle_timer #(
    parameter int IDLE_CHARS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_char_stb,
    input  logic char_tick,
    output logic idle_met
);
    localparam int LIMIT = IDLE_CHARS + 1;
    localparam int CNT_W = $clog2(LIMIT + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } idle_st_t;

    idle_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rx_char_stb) begin
            st_d.cnt = '0;
        end else if (char_tick && (st_q.cnt != CNT_W'(LIMIT))) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign idle_met = (st_q.cnt == CNT_W'(LIMIT));

    // R6: the count never passes its saturation value
    p_idle_sat_r6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(LIMIT));

    // R8: a received character always leaves the line non-idle
    p_idle_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_char_stb |=> !idle_met);

endmodule

// File: rtl/rxrel_policy.sv
module rxrel_policy
    import rxrel_pkg::*;
#(
    parameter int LVL_W   = 9,
    parameter int MAX_PKT = 64,
    parameter int LEN_W   = 7
) (
    input  logic [LVL_W-1:0] fifo_level,
    input  logic             rd_req,
    input  logic             low_lat_en,
    input  logic             idle_met,
    output rel_dec_e         dec,
    output logic [LEN_W-1:0] len
);
    logic is_empty;
    logic is_full;

    assign is_empty = (fifo_level == '0);
    assign is_full  = (fifo_level >= LVL_W'(MAX_PKT));

    always_comb begin
        dec = DEC_NONE;
        len = '0;
        if (rd_req) begin
            if (is_empty) begin
                dec = DEC_NAK;
            end else if (is_full) begin
                dec = DEC_FULL;
                len = LEN_W'(MAX_PKT);
            end else if (low_lat_en || idle_met) begin
                dec = DEC_SHORT;
                len = LEN_W'(fifo_level);
            end else begin
                dec = DEC_NAK;
            end
        end
    end

    // R12: a length appears only with a release decision
    always_comb begin
        if (rd_req && (dec == DEC_NAK || dec == DEC_NONE)) begin
            p_len_nak_r12: assert (len == '0);
        end
    end

endmodule

// File: rtl/rxrel_rts_ctrl.sv
module rxrel_rts_ctrl #(
    parameter int LVL_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] fifo_level,
    input  logic [LVL_W-1:0] rts_thresh,
    input  logic             rts_auto_en,
    output logic             rts_n
);
    typedef struct packed {
        logic rts_n;
    } rts_st_t;

    rts_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!rts_auto_en) begin
            st_d.rts_n = 1'b1;
        end else if (fifo_level == '0) begin
            st_d.rts_n = 1'b0;
        end else begin
            st_d.rts_n = (fifo_level >= rts_thresh);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{rts_n: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign rts_n = st_q.rts_n;

    p_rts_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rts_auto_en && fifo_level == '0) |=> !rts_n);

    p_rts_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !rts_auto_en |=> rts_n);

endmodule

// File: rtl/rxrel_bulkin_gate.sv
module rxrel_bulkin_gate
    import rxrel_pkg::*;
#(
    parameter int LVL_W      = 9,
    parameter int MAX_PKT    = 64,
    parameter int IDLE_CHARS = 3,
    parameter int LEN_W      = $clog2(MAX_PKT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] fifo_level,
    input  logic             rx_char_stb,
    input  logic             char_tick,
    input  logic             low_lat_en,
    input  logic             rts_auto_en,
    input  logic [LVL_W-1:0] rts_thresh,
    input  logic             rd_req,
    output logic             rsp_ack,
    output logic             rsp_nak,
    output logic [LEN_W-1:0] xfer_len,
    output logic             rts_n
);
    typedef struct packed {
        logic             ack;
        logic             nak;
        logic [LEN_W-1:0] len;
    } rsp_st_t;

    rsp_st_t  rsp_d, rsp_q;
    logic     idle_met;
    rel_dec_e dec;
    logic [LEN_W-1:0] dec_len;

    rxrel_idle_timer #(
        .IDLE_CHARS (IDLE_CHARS)
    ) u_idle (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_char_stb (rx_char_stb),
        .char_tick   (char_tick),
        .idle_met    (idle_met)
    );

    rxrel_policy #(
        .LVL_W   (LVL_W),
        .MAX_PKT (MAX_PKT),
        .LEN_W   (LEN_W)
    ) u_policy (
        .fifo_level (fifo_level),
        .rd_req     (rd_req),
        .low_lat_en (low_lat_en),
        .idle_met   (idle_met),
        .dec        (dec),
        .len        (dec_len)
    );

    rxrel_rts_ctrl #(
        .LVL_W (LVL_W)
    ) u_rts (
        .clk         (clk),
        .rst_n       (rst_n),
        .fifo_level  (fifo_level),
        .rts_thresh  (rts_thresh),
        .rts_auto_en (rts_auto_en),
        .rts_n       (rts_n)
    );

    always_comb begin
        rsp_d     = '0;
        rsp_d.ack = (dec == DEC_FULL) || (dec == DEC_SHORT);
        rsp_d.nak = (dec == DEC_NAK);
        rsp_d.len = rsp_d.ack ? dec_len : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_ack  = rsp_q.ack;
    assign rsp_nak  = rsp_q.nak;
    assign xfer_len = rsp_q.len;

    p_one_rsp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> (rsp_ack ^ rsp_nak));

    p_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> (!rsp_ack && !rsp_nak));

    p_full_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && fifo_level >= LVL_W'(MAX_PKT)) |=>
        (rsp_ack && xfer_len == LEN_W'(MAX_PKT)));

    p_empty_nak_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && fifo_level == '0) |=> rsp_nak);

    p_lowlat_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && low_lat_en && fifo_level != '0) |=> rsp_ack);

    p_len_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_ack |-> (xfer_len == '0));

endmodule

// File: tb/test_rxrel_bulkin_gate.sv
module test_rxrel_bulkin_gate;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [8:0] fifo_level = '0;
    logic       rx_char_stb = 1'b0;
    logic       char_tick = 1'b0;
    logic       low_lat_en = 1'b0;
    logic       rts_auto_en = 1'b0;
    logic [8:0] rts_thresh = '0;
    logic       rd_req = 1'b0;
    logic       rsp_ack;
    logic       rsp_nak;
    logic [6:0] xfer_len;
    logic       rts_n;

    int n_run = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rxrel_bulkin_gate i_rxrel_bulkin_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .fifo_level  (fifo_level),
        .rx_char_stb (rx_char_stb),
        .char_tick   (char_tick),
        .low_lat_en  (low_lat_en),
        .rts_auto_en (rts_auto_en),
        .rts_thresh  (rts_thresh),
        .rd_req      (rd_req),
        .rsp_ack     (rsp_ack),
        .rsp_nak     (rsp_nak),
        .xfer_len    (xfer_len),
        .rts_n       (rts_n)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // one request; ack=1 expects accept with length, ack=0 expects refuse
    task automatic req_check(input string req, input int lvl, input bit ack, input int len);
        @(negedge clk);
        fifo_level = 9'(lvl);
        rd_req = 1'b1;
        @(posedge clk);
        #1;
        chk(req, {rsp_ack, rsp_nak}, ack ? 2 : 1);
        chk(req, int'(xfer_len), ack ? len : 0);
        @(negedge clk);
        rd_req = 1'b0;
    endtask

    task automatic pulse_tick(input bit stb);
        @(negedge clk);
        char_tick = 1'b1;
        rx_char_stb = stb;
        @(negedge clk);
        char_tick = 1'b0;
        rx_char_stb = 1'b0;
    endtask

    task automatic pulse_char();
        @(negedge clk);
        rx_char_stb = 1'b1;
        @(negedge clk);
        rx_char_stb = 1'b0;
    endtask

    task automatic rts_check(input string req, input bit en, input int lvl, input int th, input int exp);
        @(negedge clk);
        rts_auto_en = en;
        fifo_level = 9'(lvl);
        rts_thresh = 9'(th);
        @(posedge clk);
        #1;
        chk(req, int'(rts_n), exp);
    endtask

    task automatic t_reset();
        @(posedge clk);
        #1;
        chk("R1 ack in reset", int'(rsp_ack), 0);
        chk("R1 nak in reset", int'(rsp_nak), 0);
        chk("R1 len in reset", int'(xfer_len), 0);
        chk("R1 rts_n in reset", int'(rts_n), 1);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        chk("R1 ack after reset", int'(rsp_ack), 0);
        chk("R1 rts_n after reset", int'(rts_n), 1);
    endtask

    task automatic t_empty();
        req_check("R4 empty normal", 0, 0, 0);
        low_lat_en = 1'b1;
        req_check("R4 empty lowlat", 0, 0, 0);
        low_lat_en = 1'b0;
    endtask

    task automatic t_full();
        req_check("R3 exactly 64", 64, 1, 64);
        req_check("R3 300 bytes", 300, 1, 64);
        @(posedge clk);
        #1;
        chk("R2 no request no ack", int'(rsp_ack), 0);
        chk("R2 no request no nak", int'(rsp_nak), 0);
        chk("R12 len idle", int'(xfer_len), 0);
    endtask

    task automatic t_short_busy();
        pulse_char();
        req_check("R5 short busy 63", 63, 0, 0);
        req_check("R5 short busy 1", 1, 0, 0);
    endtask

    task automatic t_idle();
        pulse_char();
        for (int i = 0; i < 3; i++) pulse_tick(1'b0);
        req_check("R6 three ticks not idle", 20, 0, 0);
        pulse_tick(1'b0);
        req_check("R6 fourth tick idle", 20, 1, 20);
        for (int i = 0; i < 5; i++) pulse_tick(1'b0);
        req_check("R6 saturated idle", 7, 1, 7);
        pulse_char();
        req_check("R8 char restarts", 7, 0, 0);
    endtask

    task automatic t_same_cycle();
        for (int i = 0; i < 4; i++) pulse_tick(1'b0);
        pulse_tick(1'b1);
        for (int i = 0; i < 3; i++) pulse_tick(1'b0);
        req_check("R8 strobe beats tick", 9, 0, 0);
        pulse_tick(1'b0);
        req_check("R8 idle after restart", 9, 1, 9);
    endtask

    task automatic t_lowlat();
        pulse_char();
        low_lat_en = 1'b1;
        req_check("R7 lowlat short", 33, 1, 33);
        req_check("R7 lowlat one", 1, 1, 1);
        req_check("R3 lowlat full", 100, 1, 64);
        low_lat_en = 1'b0;
    endtask

    task automatic t_rts();
        rts_check("R9 below thresh", 1'b1, 9, 10, 0);
        rts_check("R9 at thresh", 1'b1, 10, 10, 1);
        rts_check("R9 above thresh", 1'b1, 200, 10, 1);
        rts_check("R9 drained below", 1'b1, 5, 10, 0);
        rts_check("R10 empty zero thresh", 1'b1, 0, 0, 0);
        rts_check("R9 zero thresh nonzero", 1'b1, 1, 0, 1);
        rts_check("R11 auto off low fill", 1'b0, 3, 10, 1);
        rts_check("R11 auto off empty", 1'b0, 0, 10, 1);
    endtask

    initial begin
        t_reset();
        t_empty();
        t_full();
        t_short_busy();
        t_idle();
        t_same_cycle();
        t_lowlat();
        t_rts();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule